// File: doc/BRIEF.md
# SPI Byte Engine with Overrun-Discard Receive Buffering

This block moves bytes over a four-wire serial link in clock mode 0, most significant bit first. It acts either as the bus master, generating the serial clock from the system clock through a programmable divider and driving its own select line, or as a slave, following a select line and serial clock from outside. On both sides the data path is the same: a one-byte transmit holding register, a shift register, and a one-byte receive holding register. The host writes bytes and reads results through a strobe interface, and reads three status flags.

The receive side is deliberately simple. When a byte finishes while the receive holding register is still unread, the new byte is discarded and the old one stays. The shift register is never used as a hidden second receive stage. By default this loss is silent. A build parameter adds a sticky overrun flag with its own interrupt line. The flag does not stall the link.

In master mode, a byte that is waiting in the transmit holding register when the current byte ends is started at once. The select line stays low across the two bytes. In slave mode, the byte waiting at the moment select is asserted, or at the end of each byte, is sent. If nothing is waiting, the slave sends zero.

Top module: `spi_byte_engine`

## Requirements
- R1: After reset, status reads tx-empty=1, rx-full=0, overrun=0 (status bit 0 = tx-empty, bit 1 = rx-full, bit 2 = overrun). The select output is high and the serial clock output is low.
- R2: A host write while tx-empty=1 stores the byte and drops tx-empty until that byte enters the shift register. A write while tx-empty=0 is ignored, and the queued byte is sent unchanged.
- R3: In master mode the serial clock idles low, and each of its half periods lasts cfg_div+1 system clocks. The outgoing bit changes after the falling edge and the incoming bit is sampled on the rising edge, MSB first. The select output stays low while a byte is being shifted.
- R4: In master mode, if the transmit holding register is full when a byte ends, the next byte starts with no host action, and select stays low across both bytes (16 rising clock edges in one select-low period).
- R5: A completed byte is placed in the receive holding register and sets rx-full. A data-read strobe clears rx-full.
- R6: A byte that completes while rx-full=1 (and no data read happens in that cycle) is discarded. The receive register keeps the older byte and rx-full stays 1.
- R7: A discarded byte is never delivered later. After the old byte is read, rx-full stays 0 even if no further transfer follows.
- R8: With the overrun option off (default), an overrun leaves status bit 2 and the overrun interrupt at 0.
- R9: With the overrun option on, an overrun sets a sticky status bit 2 and the overrun interrupt. A data read alone does not clear it. A status read followed later by a data read does clear it. Transfers keep working while it is set.
- R10: In slave mode, with select low, a byte is received from sdi sampled on rising serial clock edges, MSB first, and completes on the eighth falling edge. Meanwhile sdo shows the byte that was waiting when select fell, or zero if none was waiting.
- R11: In slave mode, raising select part-way through a byte resets the bit count, so the next select-low period receives a full new byte.
- R12: The interrupt outputs follow the flags: irq_tx equals tx-empty, irq_rx equals rx-full, and irq_ovr equals the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cfg_div | input | DIV_W | Master serial clock half period, in system clocks, minus one |
| wr_en | input | 1 | Host write strobe for the transmit byte |
| wr_data | input | DATA_W | Host transmit byte |
| rd_data_en | input | 1 | Host read strobe for the receive byte |
| rd_stat_en | input | 1 | Host read strobe for status (arms overrun clear) |
| rd_data | output | DATA_W | Receive holding register contents |
| stat | output | 3 | {overrun, rx-full, tx-empty} |
| irq_tx | output | 1 | Transmit-room interrupt |
| irq_rx | output | 1 | Receive-ready interrupt |
| irq_ovr | output | 1 | Overrun interrupt (option) |
| sck_o | output | 1 | Master serial clock |
| sel_n_o | output | 1 | Master select, active low |
| sck_i | input | 1 | Slave serial clock |
| sel_n_i | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in (master: from slave; slave: from master) |
| sdo | output | 1 | Serial data out (master: to slave; slave: to master) |

## Verification
The assertions assume that cfg_master and cfg_div stay constant while a byte is being shifted. They also assume that the slave-side clock, select and data levels each last several system clocks, so that the input synchronizer sees every edge. The stimulus changes the mode and the divider only when the engine is idle. It drives the slave pins with phases eight system clocks long, and it changes sdi only in the low half of the serial clock. Random bytes, dividers and loopback polarity run in master mode. Directed sequences cover queued writes, ignored writes, overrun with and without the flag, and a select line dropped mid-byte.

// File: rtl/spi_be_pkg.sv
package spi_be_pkg;
  typedef struct packed {
    logic ovr;
    logic rx_full;
    logic tx_empty;
  } stat_t;
  localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/spi_be_sckgen.sv
module spi_be_sckgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             tick;

  always_comb begin
    tick  = en && (cnt_q == div);
    rise  = tick && !sck_q;
    fall  = tick && sck_q;
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!en) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck = sck_q;

  // R3: the divider never runs past the programmed half period
  a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $stable(div) && cnt_q == div) |=> (cnt_q == '0));
endmodule

// File: rtl/spi_be_insync.sv
module spi_be_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic sel_n_i,
  input  logic sdi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_act,
  output logic sel_start,
  output logic sdi_s
);
  localparam logic [2:0] IDLE_LVL = 3'b010; // {sdi, sel_n, sck}
  logic [2:0] chain_q [STAGES];
  logic [2:0] sync;
  logic       sck_p, sel_n_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= IDLE_LVL;
      sck_p   <= 1'b0;
      sel_n_p <= 1'b1;
    end else begin
      chain_q[0] <= {sdi_i, sel_n_i, sck_i};
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      sck_p   <= sync[0];
      sel_n_p <= sync[1];
    end
  end

  always_comb begin
    sync      = chain_q[STAGES-1];
    sck_rise  = sync[0] && !sck_p;
    sck_fall  = !sync[0] && sck_p;
    sel_act   = !sync[1];
    sel_start = !sync[1] && sel_n_p;
    sdi_s     = sync[2];
  end
endmodule

// File: rtl/spi_be_core.sv
module spi_be_core #(
  parameter int DATA_W = 8,
  parameter bit OVR_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              sel_act,
  input  logic              sel_start,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_data_en,
  input  logic              rd_stat_en,
  output logic              busy,
  output logic              sdo,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              ovr,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] txbuf_q, txbuf_d, shreg_q, shreg_d, rxbuf_q, rxbuf_d;
  logic [DATA_W-1:0] word_in, reload;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic              samp_q, samp_d, busy_q, busy_d;
  logic              txe_q, txe_d, rxf_q, rxf_d;
  logic              ev_ok, rx_free, done;

  always_comb begin
    txbuf_d  = txbuf_q;
    shreg_d  = shreg_q;
    rxbuf_d  = rxbuf_q;
    bitcnt_d = bitcnt_q;
    samp_d   = samp_q;
    busy_d   = busy_q;
    txe_d    = txe_q;
    rxf_d    = rxf_q;
    done     = 1'b0;
    rx_free  = !rxf_q || rd_data_en;
    word_in  = {shreg_q[DATA_W-2:0], samp_q};
    reload   = txe_q ? '0 : txbuf_q;
    ev_ok    = busy_q && (master || sel_act);

    if (rd_data_en) rxf_d = 1'b0;

    if (master) begin
      if (!busy_q && !txe_q) begin
        shreg_d  = txbuf_q;
        txe_d    = 1'b1;
        busy_d   = 1'b1;
        bitcnt_d = '0;
      end
    end else if (!sel_act) begin
      busy_d   = 1'b0;
      bitcnt_d = '0;
    end else if (sel_start) begin
      shreg_d  = reload;
      txe_d    = 1'b1;
      busy_d   = 1'b1;
      bitcnt_d = '0;
    end

    if (ev_ok && rise) samp_d = sdi;

    if (ev_ok && fall) begin
      if (bitcnt_q == LAST_BIT) begin
        done     = 1'b1;
        bitcnt_d = '0;
        if (rx_free) begin
          rxbuf_d = word_in;
          rxf_d   = 1'b1;
        end
        if (!txe_q) begin
          shreg_d = txbuf_q;
          txe_d   = 1'b1;
        end else if (master) begin
          busy_d = 1'b0;
        end else begin
          shreg_d = '0;
        end
      end else begin
        bitcnt_d = bitcnt_q + 1'b1;
        shreg_d  = word_in;
      end
    end

    if (wr_en && txe_q) begin
      txbuf_d = wr_data;
      txe_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf_q  <= '0;
      shreg_q  <= '0;
      rxbuf_q  <= '0;
      bitcnt_q <= '0;
      samp_q   <= 1'b0;
      busy_q   <= 1'b0;
      txe_q    <= 1'b1;
      rxf_q    <= 1'b0;
    end else begin
      txbuf_q  <= txbuf_d;
      shreg_q  <= shreg_d;
      rxbuf_q  <= rxbuf_d;
      bitcnt_q <= bitcnt_d;
      samp_q   <= samp_d;
      busy_q   <= busy_d;
      txe_q    <= txe_d;
      rxf_q    <= rxf_d;
    end
  end

  generate
    if (OVR_EN) begin : g_ovr
      logic ovr_q, ovr_d, arm_q, arm_d;
      always_comb begin
        ovr_d = ovr_q;
        arm_d = arm_q;
        if (rd_stat_en && ovr_q) arm_d = 1'b1;
        if (rd_data_en) begin
          arm_d = 1'b0;
          if (arm_q) ovr_d = 1'b0;
        end
        if (done && !rx_free) ovr_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ovr_q <= 1'b0;
          arm_q <= 1'b0;
        end else begin
          ovr_q <= ovr_d;
          arm_q <= arm_d;
        end
      end
      assign ovr = ovr_q;
      // R9: flag survives any cycle without a data read
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !rd_data_en) |=> ovr_q);
    end else begin : g_no_ovr
      assign ovr = 1'b0;
    end
  endgenerate

  assign busy     = busy_q;
  assign sdo      = shreg_q[DATA_W-1];
  assign tx_empty = txe_q;
  assign rx_full  = rxf_q;
  assign rx_data  = rxbuf_q;

  // R2: write into an occupied holding register leaves it untouched
  a_r2_ignore_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !txe_q) |=> $stable(txbuf_q));
  // R2: accepted write lands in the holding register
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && txe_q) |=> (!txe_q && txbuf_q == $past(wr_data)));
  // R5: finished byte always leaves rx-full set
  a_r5_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rxf_q);
  // R6: an unread byte is never overwritten
  a_r6_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_q && !rd_data_en) |=> $stable(rxbuf_q));
  // R11: select high in slave mode clears the bit position
  a_r11_sel_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !sel_act) |=> (bitcnt_q == '0));
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_be_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit OVR_EN      = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_data_en,
  input  logic              rd_stat_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] stat,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_ovr,
  output logic              sck_o,
  output logic              sel_n_o,
  input  logic              sck_i,
  input  logic              sel_n_i,
  input  logic              sdi,
  output logic              sdo
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  logic       busy, m_rise, m_fall, s_rise, s_fall, sel_act, sel_start, sdi_s;
  logic       ev_rise, ev_fall, sdi_core, txe, rxf, ovr;
  stat_t      st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  spi_be_sckgen #(.DIV_W(DIV_W)) sckgen_i (
    .clk(clk), .rst_n(rst_n_s), .en(cfg_master && busy), .div(cfg_div),
    .sck(sck_o), .rise(m_rise), .fall(m_fall)
  );

  spi_be_insync #(.STAGES(SYNC_STAGES)) insync_i (
    .clk(clk), .rst_n(rst_n_s), .sck_i(sck_i), .sel_n_i(sel_n_i), .sdi_i(sdi),
    .sck_rise(s_rise), .sck_fall(s_fall), .sel_act(sel_act),
    .sel_start(sel_start), .sdi_s(sdi_s)
  );

  always_comb begin
    ev_rise  = cfg_master ? m_rise : s_rise;
    ev_fall  = cfg_master ? m_fall : s_fall;
    sdi_core = cfg_master ? sdi : sdi_s;
  end

  spi_be_core #(.DATA_W(DATA_W), .OVR_EN(OVR_EN)) core_i (
    .clk(clk), .rst_n(rst_n_s), .master(cfg_master), .sel_act(sel_act),
    .sel_start(sel_start), .rise(ev_rise), .fall(ev_fall), .sdi(sdi_core),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data_en(rd_data_en),
    .rd_stat_en(rd_stat_en), .busy(busy), .sdo(sdo), .tx_empty(txe),
    .rx_full(rxf), .ovr(ovr), .rx_data(rd_data)
  );

  always_comb begin
    st.ovr      = ovr;
    st.rx_full  = rxf;
    st.tx_empty = txe;
  end

  assign stat    = st;
  assign irq_tx  = txe;
  assign irq_rx  = rxf;
  assign irq_ovr = ovr;
  assign sel_n_o = !(cfg_master && busy);

  // R3: serial clock output is low whenever the master select is idle
  a_r3_idle_sck_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_master && $past(cfg_master) && sel_n_o) |-> !sck_o);
  // R4: select stays low from one rising clock edge to the next within a transfer
  a_r4_sel_held: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_master && $stable(cfg_master) && $rose(sck_o)) |-> !sel_n_o);
endmodule

// File: tb/spi_byte_engine_tb_top.sv
module spi_byte_engine_tb_top;
  logic       clk, rst_n;
  logic       cfg_master;
  logic [7:0] cfg_div;
  logic       wr_en, rd_data_en, rd_stat_en;
  logic [7:0] wr_data;
  logic       sck_i, sel_n_i, sdi_drv, bench_slave, loop_inv;
  logic [7:0] rd_a, rd_b;
  logic [2:0] st_a, st_b;
  logic       itx_a, irx_a, iov_a, itx_b, irx_b, iov_b;
  logic       sck_a, seln_a, sdo_a, sck_b, seln_b, sdo_b, sdi_w;
  int         checks, errors;

  assign sdi_w = bench_slave ? sdi_drv : (loop_inv ? ~sdo_a : sdo_a);

  spi_byte_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_div(cfg_div),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data_en(rd_data_en), .rd_stat_en(rd_stat_en),
    .rd_data(rd_a), .stat(st_a), .irq_tx(itx_a), .irq_rx(irx_a), .irq_ovr(iov_a),
    .sck_o(sck_a), .sel_n_o(seln_a), .sck_i(sck_i), .sel_n_i(sel_n_i),
    .sdi(sdi_w), .sdo(sdo_a)
  );

  spi_byte_engine #(.OVR_EN(1'b1)) dut_ovr_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_div(cfg_div),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data_en(rd_data_en), .rd_stat_en(rd_stat_en),
    .rd_data(rd_b), .stat(st_b), .irq_tx(itx_b), .irq_rx(irx_b), .irq_ovr(iov_b),
    .sck_o(sck_b), .sel_n_o(seln_b), .sck_i(sck_i), .sel_n_i(sel_n_i),
    .sdi(sdi_w), .sdo(sdo_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] exp_rx(input logic [7:0] b, input bit inv);
    return inv ? ~b : b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [7:0] b);
    @(negedge clk); wr_data = b; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_rd(output logic [7:0] b);
    @(negedge clk); b = rd_a; rd_data_en = 1'b1;
    @(negedge clk); rd_data_en = 1'b0;
  endtask

  task automatic host_stat();
    @(negedge clk); rd_stat_en = 1'b1;
    @(negedge clk); rd_stat_en = 1'b0;
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 3000 && !st_a[1]; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    tick(2);
    for (int i = 0; i < 3000 && !(seln_a && st_a[0]); i++) @(negedge clk);
    tick(4);
  endtask

  task automatic slave_xfer(input logic [7:0] m, input int nbits, output logic [7:0] got);
    got = '0;
    sel_n_i = 1'b0;
    tick(8);
    for (int k = 0; k < nbits; k++) begin
      sdi_drv = m[7-k];
      tick(8);
      got[7-k] = sdo_a;
      sck_i = 1'b1;
      tick(8);
      sck_i = 1'b0;
      tick(8);
    end
    tick(8);
    sel_n_i = 1'b1;
    tick(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b, got, a_byte, b_byte;
    int cnt, hi;
    checks = 0; errors = 0;
    rst_n = 1'b0; cfg_master = 1'b1; cfg_div = 8'd0;
    wr_en = 1'b0; wr_data = '0; rd_data_en = 1'b0; rd_stat_en = 1'b0;
    sck_i = 1'b0; sel_n_i = 1'b1; sdi_drv = 1'b0; bench_slave = 1'b0; loop_inv = 1'b0;
    void'($urandom(32'h5eed_1234));
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk("R1 stat", st_a, 3'b001);
    chk("R1 stat opt", st_b, 3'b001);
    chk("R1 sel", seln_a, 1);
    chk("R1 sck", sck_a, 0);
    chk("R12 irq_tx reset", itx_a, 1);
    chk("R12 irq_rx reset", irx_a, 0);

    // R3 half period and single loopback transfer
    cfg_div = 8'd2; loop_inv = 1'b1;
    host_wr(8'hA5);
    chk("R2 tx_empty low after write", st_a[0], 0);
    for (int i = 0; i < 200 && !sck_a; i++) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 200 && sck_a; i++) begin hi++; @(negedge clk); end
    chk("R3 half period", hi, 3);
    wait_rx();
    chk("R5 rx_full", st_a[1], 1);
    chk("R3 rx data", rd_a, exp_rx(8'hA5, 1'b1));
    host_rd(got);
    chk("R5 rx_full cleared", st_a[1], 0);
    wait_idle();

    // R4 back to back, R2 ignored write, R3 bit order
    cfg_div = 8'd1; loop_inv = 1'b0;
    a_byte = 8'h96; b_byte = 8'h3C;
    fork
      begin
        host_wr(a_byte);
        for (int i = 0; i < 100 && !st_a[0]; i++) @(negedge clk);
        host_wr(b_byte);
        host_wr(8'hFF);
        wait_rx();
        host_rd(got);
        chk("R4 first byte", got, a_byte);
        wait_rx();
        host_rd(got);
        chk("R2 queued byte unchanged", got, b_byte);
      end
      begin
        logic [15:0] bits;
        logic prev;
        bits = '0; cnt = 0;
        for (int i = 0; i < 500 && seln_a; i++) @(negedge clk);
        prev = sck_a;
        for (int i = 0; i < 2000 && !seln_a; i++) begin
          @(negedge clk);
          if (sck_a && !prev) begin bits = {bits[14:0], sdo_a}; cnt++; end
          prev = sck_a;
        end
        chk("R4 rising edges in one select", cnt, 16);
        chk("R3 msb first bits", bits, {a_byte, b_byte});
      end
    join
    tick(40);
    chk("R2 ignored write not sent", st_a[1], 0);

    // R6 R7 R8 R9 overrun
    cfg_div = 8'd0; loop_inv = 1'b0;
    host_wr(8'h11);
    for (int i = 0; i < 100 && !st_a[0]; i++) @(negedge clk);
    host_wr(8'h22);
    wait_idle();
    chk("R6 rx_full kept", st_a[1], 1);
    chk("R6 old byte kept", rd_a, 8'h11);
    chk("R8 no flag default", st_a[2], 0);
    chk("R8 no irq default", iov_a, 0);
    chk("R9 flag set", st_b[2], 1);
    chk("R12 irq_ovr", iov_b, 1);
    host_rd(got);
    tick(20);
    chk("R7 lost byte never appears", st_a[1], 0);
    chk("R9 data read alone keeps flag", st_b[2], 1);
    host_stat();
    host_rd(got);
    chk("R9 status then data clears", st_b[2], 0);
    host_wr(8'h5A);
    wait_rx();
    chk("R9 later transfer works", rd_b, 8'h5A);
    host_rd(got);
    wait_idle();

    // random master traffic
    for (int it = 0; it < 24; it++) begin
      b = 8'($urandom);
      cfg_div = 8'($urandom_range(0, 3));
      loop_inv = 1'($urandom);
      host_wr(b);
      wait_rx();
      chk("R5 random rx", rd_a, exp_rx(b, loop_inv));
      chk("R12 irq_rx follows", irx_a, st_a[1]);
      host_rd(got);
      chk("R5 random clear", st_a[1], 0);
      wait_idle();
      chk("R12 irq_tx follows", itx_a, st_a[0]);
    end

    // R10 R11 slave mode
    cfg_master = 1'b0; bench_slave = 1'b1;
    tick(4);
    host_wr(8'hC3);
    slave_xfer(8'h6B, 8, got);
    chk("R10 slave sent", got, 8'hC3);
    chk("R10 slave received", rd_a, 8'h6B);
    chk("R10 slave tx empty", st_a[0], 1);
    host_rd(got);
    slave_xfer(8'h81, 8, got);
    chk("R10 slave sends zero when empty", got, 8'h00);
    host_rd(got);
    chk("R10 slave rx second", got, 8'h81);
    slave_xfer(8'hE0, 3, got);
    chk("R11 partial byte not delivered", st_a[1], 0);
    slave_xfer(8'h4D, 8, got);
    chk("R11 full byte after reselect", rd_a, 8'h4D);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule